// File: doc/BRIEF.md
# Base Timer with Overflow Interrupt

This block is an 8-bit up-counting interval timer for a small microcontroller. It runs on the 4 MHz system clock and divides it internally. The divider gives a clock enable at half rate for the CPU and a one-cycle tick at quarter rate, which is 1 µs, to advance the count. Software controls the timer through three write-only locations on a plain write bus made of an address, a write strobe and a data byte. One location presets the count. One holds an active-low run bit. One clears the pending interrupt.

Each time the count steps from FFH to 00H, the block latches a sticky pending flag. The counter then keeps going from 00H and does not reload the preset. A preset P therefore gives an overflow interval of 256 − P ticks, anywhere from 1 µs to 256 µs. The pending flag reaches the CPU as an interrupt only while the timer-interrupt enable input is high. Software cannot read the flag. A write of 1 to the clear location drops it. The block also exports the interrupt vector address, FFFEH.

Top module: `btmr_top`

## Requirements
- R1: `cpu_ce_o` is high on every second clock cycle. `tick_o` is high for exactly one cycle in every four, and only in a cycle where `cpu_ce_o` is also high.
- R2: After reset the count is 00H, the timer is stopped (the count stays at 00H with no writes), `irq_o` is low and the pending flag is clear.
- R3: A write to address 00C0H loads the data byte into the count at the next clock edge. This happens whether the timer runs or not. If the load lands on the same edge as a tick, the load wins.
- R4: Bit 0 of a write to 00C1H sets the run state: 0 runs the timer and 1 stops it. While stopped, the count holds its value. Data bits 7:1 of that write have no effect.
- R5: While running, the count goes up by one on each edge where `tick_o` is high.
- R6: The tick that moves the count from FFH to 00H sets the pending flag. The count then carries on from 00H, so a preset P followed by a run gives 256 − P ticks until the flag sets.
- R7: The pending flag stays set until a write to 00C2H with data bit 0 equal to 1. Such a write with bit 0 equal to 0 leaves the flag unchanged.
- R8: If an overflow and a clearing write fall on the same edge, the flag ends up set.
- R9: `irq_o` is high only when the pending flag is set and `tmr_ie_i` is high. The flag sets on overflow even while `tmr_ie_i` is low.
- R10: `vector_o` carries the constant FFFEH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 4 MHz system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| addr_i | input | 16 | Write address |
| wdata_i | input | 8 | Write data |
| tmr_ie_i | input | 1 | Timer interrupt enable |
| cpu_ce_o | output | 1 | 2 MHz clock enable for the CPU |
| tick_o | output | 1 | 1 MHz timer tick |
| count_o | output | 8 | Current count |
| irq_o | output | 1 | Interrupt request to the CPU |
| vector_o | output | 16 | Interrupt vector address |

## Verification
The assertions check on every cycle that the divider phase is correct, that a preset load always takes effect, and that the count holds while stopped and steps by one per tick while running. They also check that a pending flag stays set without a clearing write, that an FFH tick always sets the flag, and that a low enable always masks the interrupt. Only the bench scenarios can show the overflow interval for particular presets and the wrap to 00H with no reload. The same holds for the two write-data bits that have no effect, the set-over-clear race, and a flag latched while masked that appears once the enable rises.

// File: rtl/btmr_pkg.sv
package btmr_pkg;
  localparam int unsigned BUS_AW = 16;
  localparam logic [BUS_AW-1:0] PRESET_ADDR = 16'h00C0;
  localparam logic [BUS_AW-1:0] CTRL_ADDR   = 16'h00C1;
  localparam logic [BUS_AW-1:0] CLR_ADDR    = 16'h00C2;
  localparam logic [BUS_AW-1:0] IRQ_VECTOR  = 16'hFFFE;

  typedef struct packed {
    logic preset;
    logic ctrl;
    logic clr;
  } wr_sel_t;
endpackage

// File: rtl/btmr_tick_gen.sv
module btmr_tick_gen #(
  parameter int unsigned DIV_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic cpu_ce_o,
  output logic tick_o
);
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  // half rate from LSB, full divide when all bits set
  assign cpu_ce_o = div_q[0];
  assign tick_o   = &div_q;
endmodule

// File: rtl/btmr_decode.sv
module btmr_decode
  import btmr_pkg::*;
#(
  parameter int unsigned          AW     = 16,
  parameter logic [AW-1:0]        A_PRE  = '0,
  parameter logic [AW-1:0]        A_CTRL = '0,
  parameter logic [AW-1:0]        A_CLR  = '0
) (
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output wr_sel_t       sel_o
);
  always_comb begin
    sel_o.preset = we_i && (addr_i == A_PRE);
    sel_o.ctrl   = we_i && (addr_i == A_CTRL);
    sel_o.clr    = we_i && (addr_i == A_CLR);
  end
endmodule

// File: rtl/btmr_counter.sv
module btmr_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             preset_i,
  input  logic             ctrl_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic             run_n_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_n_q;
  logic             step;

  assign step = tick_i && !run_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_n_q <= 1'b1;
    else if (ctrl_i)   run_n_q <= wdata_i[0];
  end

  // load beats increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (preset_i)  cnt_q <= wdata_i;
    else if (step)      cnt_q <= cnt_q + 1'b1;
  end

  assign ovf_o   = step && !preset_i && (&cnt_q);
  assign count_o = cnt_q;
  assign run_n_o = run_n_q;
endmodule

// File: rtl/btmr_irq.sv
module btmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic pend_o,
  output logic irq_o
);
  logic pend_q;

  // set has priority so a coincident overflow is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (set_i)  pend_q <= 1'b1;
    else if (clr_i)  pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q && ie_i;
endmodule

// File: rtl/btmr_top.sv
module btmr_top
  import btmr_pkg::*;
#(
  parameter int unsigned         CNT_W  = 8,
  parameter int unsigned         DIV_W  = 2,
  parameter int unsigned         AW     = BUS_AW,
  parameter logic [AW-1:0]       A_PRE  = PRESET_ADDR,
  parameter logic [AW-1:0]       A_CTRL = CTRL_ADDR,
  parameter logic [AW-1:0]       A_CLR  = CLR_ADDR,
  parameter logic [AW-1:0]       VEC    = IRQ_VECTOR
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             tmr_ie_i,
  output logic             cpu_ce_o,
  output logic             tick_o,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic [AW-1:0]    vector_o
);
  wr_sel_t sel;
  logic    tick;
  logic    run_n;
  logic    ovf;
  logic    pend;

  btmr_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cpu_ce_o(cpu_ce_o),
    .tick_o  (tick)
  );

  btmr_decode #(.AW(AW), .A_PRE(A_PRE), .A_CTRL(A_CTRL), .A_CLR(A_CLR)) u_dec (
    .we_i  (we_i),
    .addr_i(addr_i),
    .sel_o (sel)
  );

  btmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .preset_i(sel.preset),
    .ctrl_i  (sel.ctrl),
    .wdata_i (wdata_i),
    .count_o (count_o),
    .run_n_o (run_n),
    .ovf_o   (ovf)
  );

  btmr_irq u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ovf),
    .clr_i (sel.clr && wdata_i[0]),
    .ie_i  (tmr_ie_i),
    .pend_o(pend),
    .irq_o (irq_o)
  );

  assign tick_o   = tick;
  assign vector_o = VEC;
endmodule

// File: rtl/btmr_chk.sv
module btmr_chk #(
  parameter int unsigned   CNT_W  = 8,
  parameter int unsigned   AW     = 16,
  parameter logic [AW-1:0] A_PRE  = '0,
  parameter logic [AW-1:0] A_CLR  = '0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [AW-1:0]    addr_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic             tmr_ie_i,
  input logic             cpu_ce_o,
  input logic             tick_o,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_o,
  input logic             run_n,
  input logic             pend
);
  logic pre_wr, clr_wr;
  assign pre_wr = we_i && (addr_i == A_PRE);
  assign clr_wr = we_i && (addr_i == A_CLR) && wdata_i[0];

  // R1
  a_r1_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  a_r1_tick_on_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> cpu_ce_o);
  // R3
  a_r3_preset_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_wr |=> count_o == $past(wdata_i));
  // R4
  a_r4_stop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_n && !pre_wr) |=> $stable(count_o));
  // R5
  a_r5_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_n && tick_o && !pre_wr) |=> count_o == CNT_W'($past(count_o) + 1'b1));
  // R7
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && !clr_wr) |=> pend);
  // R6 and R8: the wrap tick always leaves the flag set
  a_r8_wrap_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_n && tick_o && !pre_wr && (&count_o)) |=> pend);
  // R9
  a_r9_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_ie_i |-> !irq_o);
endmodule

bind btmr_top btmr_chk #(.CNT_W(CNT_W), .AW(AW), .A_PRE(A_PRE), .A_CLR(A_CLR)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .tmr_ie_i(tmr_ie_i),
  .cpu_ce_o(cpu_ce_o),
  .tick_o  (tick_o),
  .count_o (count_o),
  .irq_o   (irq_o),
  .run_n   (run_n),
  .pend    (pend)
);

// File: tb/btmr_top_tb.sv
module btmr_top_tb;
  localparam logic [15:0] A_PRE  = 16'h00C0;
  localparam logic [15:0] A_CTRL = 16'h00C1;
  localparam logic [15:0] A_CLR  = 16'h00C2;
  localparam int NV = 5;
  localparam logic [7:0] PRE_V [NV] = '{8'hFF, 8'hFE, 8'hF0, 8'h80, 8'h00};
  localparam int         EXP_V [NV] = '{1, 2, 16, 128, 256};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        tmr_ie_i = 1'b1;
  logic        cpu_ce_o, tick_o, irq_o;
  logic [7:0]  count_o;
  logic [15:0] vector_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  btmr_top u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .tmr_ie_i(tmr_ie_i), .cpu_ce_o(cpu_ce_o),
    .tick_o(tick_o), .count_o(count_o), .irq_o(irq_o), .vector_o(vector_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic ticks_to_irq(output int n);
    n = 0;
    for (int i = 0; i < 3000; i++) begin
      if (irq_o) break;
      if (tick_o) n++;
      @(negedge clk_i);
    end
  endtask

  task automatic wait_tick_negedge();
    for (int i = 0; i < 8; i++) begin
      if (tick_o) break;
      @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, ce_n, tk_n;
    logic [7:0] held;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R2 reset state, R10 vector
    check(count_o == 8'h00, "R2 count", count_o, 0);
    check(!irq_o, "R2 irq", irq_o, 0);
    check(vector_o == 16'hFFFE, "R10 vector", vector_o, 16'hFFFE);
    repeat (12) @(negedge clk_i);
    check(count_o == 8'h00, "R2 stopped after reset", count_o, 0);
    // R1 divider rates
    ce_n = 0; tk_n = 0;
    for (int i = 0; i < 8; i++) begin
      if (cpu_ce_o) ce_n++;
      if (tick_o) tk_n++;
      @(negedge clk_i);
    end
    check(ce_n == 4, "R1 cpu enable rate", ce_n, 4);
    check(tk_n == 2, "R1 tick rate", tk_n, 2);

    // R6 overflow interval table
    for (int v = 0; v < NV; v++) begin
      wr(A_CTRL, 8'h01);
      wr(A_CLR, 8'h01);
      wr(A_PRE, PRE_V[v]);
      wr(A_CTRL, 8'h00);
      ticks_to_irq(n);
      check(n == EXP_V[v], "R6 interval", n, EXP_V[v]);
      check(count_o == 8'h00, "R6 wrap to 00", count_o, 0);
    end
    // R5 / R6 no reload: next tick gives 01
    wait_tick_negedge();
    @(negedge clk_i);
    check(count_o == 8'h01, "R5 R6 continue from 00", count_o, 1);

    // R7 write-1-to-clear
    wr(A_CTRL, 8'h01);
    wr(A_CLR, 8'hFE);
    check(irq_o == 1'b1, "R7 clear with bit0=0 ignored", irq_o, 1);
    wr(A_CLR, 8'h01);
    check(irq_o == 1'b0, "R7 clear with bit0=1", irq_o, 0);

    // R4 hold while stopped, ignored upper bits
    wr(A_PRE, 8'h40);
    held = count_o;
    repeat (20) @(negedge clk_i);
    check(count_o == held, "R4 hold while stopped", count_o, held);
    wr(A_CTRL, 8'hFE);
    held = count_o;
    repeat (20) @(negedge clk_i);
    check(count_o == 8'(held + 8'd5), "R4 R5 run with bits 7:1 set", count_o, 8'(held + 8'd5));

    // R3 preset on a tick edge wins
    wait_tick_negedge();
    we_i = 1'b1; addr_i = A_PRE; wdata_i = 8'h5A;
    @(negedge clk_i);
    we_i = 1'b0;
    check(count_o == 8'h5A, "R3 preset beats tick", count_o, 8'h5A);
    wr(A_CTRL, 8'h01);
    wr(A_PRE, 8'h33);
    check(count_o == 8'h33, "R3 preset while stopped", count_o, 8'h33);

    // R9 masked overflow still latches
    tmr_ie_i = 1'b0;
    wr(A_CLR, 8'h01);
    wr(A_PRE, 8'hFF);
    wr(A_CTRL, 8'h00);
    repeat (8) @(negedge clk_i);
    check(irq_o == 1'b0, "R9 masked", irq_o, 0);
    wr(A_CTRL, 8'h01);
    tmr_ie_i = 1'b1;
    #1;
    check(irq_o == 1'b1, "R9 latched while masked", irq_o, 1);

    // R8 set beats clear on the same edge
    wr(A_CLR, 8'h01);
    check(irq_o == 1'b0, "R8 setup cleared", irq_o, 0);
    wr(A_PRE, 8'hFF);
    wr(A_CTRL, 8'h00);
    wait_tick_negedge();
    we_i = 1'b1; addr_i = A_CLR; wdata_i = 8'h01;
    @(negedge clk_i);
    we_i = 1'b0;
    check(irq_o == 1'b1, "R8 set wins", irq_o, 1);
    check(count_o == 8'h00, "R8 wrapped", count_o, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule